// File: doc/BRIEF.md
# UART Idle Line Detector

This block sits beside a UART receiver and reports when the receive line has rested high for a whole character time. It samples the synchronized receive line once per bit-time tick and keeps a saturating count of consecutive high bit times. A frame-length select sets the character time to 10 or 11 bit times. An idle-type select sets where counting may start. With select 0 it starts right after the start bit, so high data bits at the end of a character and its stop bit already count. With select 1 it starts only after the stop bit.

The flag is armed by a pulse from the receiver each time a character is moved into the data register. It rises once per idle period. Software clears it in two steps: it reads the status register while the flag is up, then reads the data register. A small frame tracker inside the block finds character boundaries for the idle-type 1 mode. It treats a low sample on a tick outside a character as a start bit and follows the character for the selected number of bit times. Baud generation and data shifting are left to the receiver.

Top module: `uart_idle_detect`

## Requirements
- R1: With `long_frame` = 0 the character time is 10 bit times. The flag goes to 1 on the clock edge that follows the tick completing the 10th consecutive counted high bit time, provided the flag is armed.
- R2: With `long_frame` = 1 the character time is 11 bit times, with the same timing as R1.
- R3: With `idle_after_stop` = 0, high samples inside a character count toward idle, including trailing high data bits and the stop bit.
- R4: With `idle_after_stop` = 1, no sample inside a character counts, the stop bit included. A character begins at a tick with the line low while no character is in progress, and it spans 10 or 11 ticks per `long_frame`.
- R5: A tick with `rx_line` low resets the count of high bit times to zero, so counting restarts from the next high sample.
- R6: A `status_rd` pulse while the flag is 1, followed later by a `data_rd` pulse, clears the flag from the clock edge at which `data_rd` is sampled.
- R7: A `data_rd` pulse that has no earlier `status_rd` taken while the flag was 1 leaves the flag at 1.
- R8: Once set, the flag stays at 1 however long the line stays high, and it rises only once per idle period.
- R9: After a clear, the flag stays at 0 until a `char_loaded` pulse has been seen, however long the line stays high.
- R10: After reset the flag is 0, and it stays 0 until the first `char_loaded` pulse, even on a line that stays high.
- R11: A `char_loaded` pulse seen while the flag is 1 re-arms the detector. After the clear, the flag rises again as soon as the count is at the character time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | One-cycle pulse per bit time, at the sampling point |
| rx_line | input | 1 | Synchronized receive line, high when idle |
| long_frame | input | 1 | 0 selects a 10-bit character, 1 an 11-bit character |
| idle_after_stop | input | 1 | 0 counts from after the start bit, 1 counts only after the stop bit |
| char_loaded | input | 1 | Pulse: a received character entered the data register |
| status_rd | input | 1 | Pulse: the status register is being read |
| data_rd | input | 1 | Pulse: the data register is being read |
| idle_flag | output | 1 | Idle line detected |

## Verification
The hardest case to reach is a `char_loaded` pulse that arrives while the flag is still up and is then followed by the two-step clear. The re-arm must survive that clear, and the flag must rise again at once from a count that has already saturated. The stimulus sets the flag over a long high stretch, pulses `char_loaded` between ticks, and then issues the status and data reads. Checks sample the flag on the cycle after the clear and on the cycle after that. The two counting modes are also told apart: the same character, ending in three high data bits, is sent under each mode, and the flag edge must move by exactly the number of bit times that the character itself contributes.

// File: rtl/uart_idle_pkg.sv
package uart_idle_pkg;

    // character boundary tracker
    typedef enum logic [0:0] {
        FR_HUNT = 1'b0,   // waiting for a start bit
        FR_BITS = 1'b1    // inside a character
    } frame_state_e;

    // idle flag life cycle
    typedef enum logic [1:0] {
        FL_DISARMED = 2'd0,  // no character since last clear
        FL_ARMED    = 2'd1,  // character seen, waiting for idle time
        FL_SET      = 2'd2,  // flag up
        FL_CLR_PEND = 2'd3   // flag up, status read taken, waiting for data read
    } flag_state_e;

    function automatic int unsigned char_time(input logic long_sel,
                                              input int unsigned short_bits,
                                              input int unsigned long_bits);
        return long_sel ? long_bits : short_bits;
    endfunction

endpackage

// File: rtl/uart_idle_frame_track.sv
module uart_idle_frame_track
    import uart_idle_pkg::*;
#(
    parameter int unsigned SHORT_BITS = 10,
    parameter int unsigned LONG_BITS  = 11,
    localparam int unsigned IDX_W     = $clog2(LONG_BITS)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic rx_line,
    input  logic long_frame,
    output logic in_frame
);

    frame_state_e state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [IDX_W-1:0] last_idx;

    // ticks after the start bit: character time minus one, last one is the stop bit
    always_comb begin
        last_idx = IDX_W'(char_time(long_frame, SHORT_BITS, LONG_BITS) - 2);
    end

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            FR_HUNT: begin
                if (bit_tick && !rx_line) begin
                    state_d = FR_BITS;
                    idx_d   = '0;
                end
            end
            FR_BITS: begin
                if (bit_tick) begin
                    if (idx_q >= last_idx) begin
                        state_d = FR_HUNT;
                        idx_d   = '0;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
            end
            default: begin
                state_d = FR_HUNT;
                idx_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FR_HUNT;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        in_frame = (state_q == FR_BITS);
    end

endmodule

// File: rtl/uart_idle_bit_counter.sv
module uart_idle_bit_counter
    import uart_idle_pkg::*;
#(
    parameter int unsigned SHORT_BITS = 10,
    parameter int unsigned LONG_BITS  = 11,
    localparam int unsigned CNT_W     = $clog2(LONG_BITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             rx_line,
    input  logic             long_frame,
    input  logic             idle_after_stop,
    input  logic             in_frame,
    output logic [CNT_W-1:0] cnt,
    output logic             at_target
);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] target;
    logic             hold_zero;

    always_comb begin
        target    = CNT_W'(char_time(long_frame, SHORT_BITS, LONG_BITS));
        // a low sample, or any sample inside a character in after-stop mode
        hold_zero = !rx_line || (idle_after_stop && in_frame);
    end

    always_comb begin
        cnt_d = cnt_q;
        if (bit_tick) begin
            if (hold_zero) begin
                cnt_d = '0;
            end else if (cnt_q < target) begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        cnt       = cnt_q;
        at_target = (cnt_q >= target);
    end

endmodule

// File: rtl/uart_idle_flag_fsm.sv
module uart_idle_flag_fsm
    import uart_idle_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic at_target,
    input  logic char_loaded,
    input  logic status_rd,
    input  logic data_rd,
    output logic idle_flag
);

    flag_state_e state_q, state_d;
    logic        rearm_q, rearm_d;

    always_comb begin
        state_d = state_q;
        rearm_d = rearm_q;
        unique case (state_q)
            FL_DISARMED: begin
                if (char_loaded) begin
                    state_d = FL_ARMED;
                end
            end
            FL_ARMED: begin
                if (at_target) begin
                    state_d = FL_SET;
                    rearm_d = 1'b0;
                end
            end
            FL_SET: begin
                rearm_d = rearm_q || char_loaded;
                if (status_rd) begin
                    state_d = FL_CLR_PEND;
                end
            end
            FL_CLR_PEND: begin
                if (data_rd) begin
                    state_d = (rearm_q || char_loaded) ? FL_ARMED : FL_DISARMED;
                    rearm_d = 1'b0;
                end else begin
                    rearm_d = rearm_q || char_loaded;
                end
            end
            default: begin
                state_d = FL_DISARMED;
                rearm_d = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FL_DISARMED;
            rearm_q <= 1'b0;
        end else begin
            state_q <= state_d;
            rearm_q <= rearm_d;
        end
    end

    always_comb begin
        idle_flag = (state_q == FL_SET) || (state_q == FL_CLR_PEND);
    end

endmodule

// File: rtl/uart_idle_detect.sv
module uart_idle_detect #(
    parameter int unsigned SHORT_BITS = 10,
    parameter int unsigned LONG_BITS  = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic rx_line,
    input  logic long_frame,
    input  logic idle_after_stop,
    input  logic char_loaded,
    input  logic status_rd,
    input  logic data_rd,
    output logic idle_flag
);

    localparam int unsigned CNT_W = $clog2(LONG_BITS + 1);

    logic             in_frame;
    logic [CNT_W-1:0] idle_cnt;
    logic             at_target;

    uart_idle_frame_track #(
        .SHORT_BITS (SHORT_BITS),
        .LONG_BITS  (LONG_BITS)
    ) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick   (bit_tick),
        .rx_line    (rx_line),
        .long_frame (long_frame),
        .in_frame   (in_frame)
    );

    uart_idle_bit_counter #(
        .SHORT_BITS (SHORT_BITS),
        .LONG_BITS  (LONG_BITS)
    ) u_count (
        .clk             (clk),
        .rst_n           (rst_n),
        .bit_tick        (bit_tick),
        .rx_line         (rx_line),
        .long_frame      (long_frame),
        .idle_after_stop (idle_after_stop),
        .in_frame        (in_frame),
        .cnt             (idle_cnt),
        .at_target       (at_target)
    );

    uart_idle_flag_fsm u_flag (
        .clk         (clk),
        .rst_n       (rst_n),
        .at_target   (at_target),
        .char_loaded (char_loaded),
        .status_rd   (status_rd),
        .data_rd     (data_rd),
        .idle_flag   (idle_flag)
    );

endmodule

// File: rtl/uart_idle_detect_chk.sv
module uart_idle_detect_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_tick,
    input logic rx_line,
    input logic char_loaded,
    input logic status_rd,
    input logic data_rd,
    input logic idle_flag,
    input logic at_target,
    input logic cnt_zero
);

    logic loaded_ever;   // any char_loaded since reset
    logic char_since;    // char_loaded since the last rise was observed
    logic status_seen;   // status read taken while the flag was up

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            loaded_ever <= 1'b0;
            char_since  <= 1'b0;
            status_seen <= 1'b0;
        end else begin
            loaded_ever <= loaded_ever || char_loaded;
            if (char_loaded) begin
                char_since <= 1'b1;
            end else if (idle_flag && !status_seen && !$past(idle_flag)) begin
                char_since <= 1'b0;
            end
            if (!idle_flag) begin
                status_seen <= 1'b0;
            end else if (status_rd) begin
                status_seen <= 1'b1;
            end
        end
    end

    p_rise_needs_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle_flag) |-> $past(at_target));

    p_low_clears_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && !rx_line) |=> cnt_zero);

    p_clear_on_data_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(idle_flag) |-> $past(data_rd));

    p_lone_data_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_flag && data_rd && !status_seen) |=> idle_flag);

    p_rise_needs_char_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle_flag) |-> char_since);

    p_quiet_after_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !loaded_ever |-> !idle_flag);

endmodule

bind uart_idle_detect uart_idle_detect_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_tick    (bit_tick),
    .rx_line     (rx_line),
    .char_loaded (char_loaded),
    .status_rd   (status_rd),
    .data_rd     (data_rd),
    .idle_flag   (idle_flag),
    .at_target   (at_target),
    .cnt_zero    (idle_cnt == '0)
);

// File: tb/uart_idle_detect_bench.sv
`timescale 1ns/1ps
module uart_idle_detect_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_tick = 1'b0;
    logic rx_line = 1'b1;
    logic long_frame = 1'b0;
    logic idle_after_stop = 1'b0;
    logic char_loaded = 1'b0;
    logic status_rd = 1'b0;
    logic data_rd = 1'b0;
    logic idle_flag;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;
    string cur_req = "R10";

    always #10 clk = ~clk;   // 50 MHz

    uart_idle_detect u_uart_idle_detect (
        .clk             (clk),
        .rst_n           (rst_n),
        .bit_tick        (bit_tick),
        .rx_line         (rx_line),
        .long_frame      (long_frame),
        .idle_after_stop (idle_after_stop),
        .char_loaded     (char_loaded),
        .status_rd       (status_rd),
        .data_rd         (data_rd),
        .idle_flag       (idle_flag)
    );

    // behavioural reference model
    int m_cnt, m_bits, m_tgt;
    bit m_inframe, m_armed, m_flag, m_pend, m_rearm;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_bits = 0; m_inframe = 0;
            m_armed = 0; m_flag = 0; m_pend = 0; m_rearm = 0;
        end else begin
            m_tgt = long_frame ? 11 : 10;
            if (!m_flag) begin
                if (m_armed && m_cnt >= m_tgt) begin
                    m_flag = 1; m_armed = 0; m_pend = 0; m_rearm = 0;
                end else if (char_loaded) begin
                    m_armed = 1;
                end
            end else begin
                if (m_pend && data_rd) begin
                    m_flag = 0; m_armed = m_rearm || char_loaded;
                    m_rearm = 0; m_pend = 0;
                end else begin
                    if (char_loaded) m_rearm = 1;
                    if (status_rd) m_pend = 1;
                end
            end
            if (bit_tick) begin
                if (!rx_line || (idle_after_stop && m_inframe)) m_cnt = 0;
                else if (m_cnt < m_tgt) m_cnt = m_cnt + 1;
                if (!m_inframe) begin
                    if (!rx_line) begin m_inframe = 1; m_bits = 0; end
                end else if (m_bits >= m_tgt - 2) begin
                    m_inframe = 0;
                end else begin
                    m_bits = m_bits + 1;
                end
            end
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            checks++;
            if (idle_flag !== m_flag) begin
                fails++;
                $display("FAIL %s model compare t=%0t: actual %0b expected %0b",
                         cur_req, $time, idle_flag, m_flag);
            end
        end
    end

    task automatic check(input string req, input logic exp, input string what);
        checks++;
        if (idle_flag !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, idle_flag, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // one bit time: tick cycle then a quiet cycle (optional load pulse)
    task automatic bit_time(input logic b, input logic load);
        bit_tick = 1'b1; rx_line = b;
        step();
        bit_tick = 1'b0; char_loaded = load;
        step();
        char_loaded = 1'b0; rx_line = 1'b1;
    endtask

    task automatic highs(input int n);
        for (int i = 0; i < n; i++) bit_time(1'b1, 1'b0);
    endtask

    // start bit, data bits (LSB first), stop bit with a load pulse after it
    task automatic send_char(input logic [8:0] data, input int ndata);
        bit_time(1'b0, 1'b0);
        for (int i = 0; i < ndata; i++) bit_time(data[i], 1'b0);
        bit_time(1'b1, 1'b1);
    endtask

    task automatic pulse_status();
        status_rd = 1'b1; step(); status_rd = 1'b0;
    endtask

    task automatic pulse_data();
        data_rd = 1'b1; step(); data_rd = 1'b0;
    endtask

    task automatic clear_flag();
        pulse_status(); pulse_data(); step();
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            finished = 1'b1;
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        cur_req = "R10";
        check("R10", 1'b0, "flag after reset");
        highs(30);
        check("R10", 1'b0, "long high line before any character");

        // R1: short frame, mode 0, all-zero data, stop counts as 1
        cur_req = "R1";
        send_char(9'h000, 8);
        highs(8);
        check("R1", 1'b0, "9 of 10 bit times");
        highs(1);
        check("R1", 1'b1, "10 of 10 bit times");

        cur_req = "R8";
        highs(40);
        check("R8", 1'b1, "flag held over long idle");

        cur_req = "R7";
        pulse_data(); step();
        check("R7", 1'b1, "lone data read");

        cur_req = "R6";
        pulse_status();
        check("R6", 1'b1, "after status read only");
        pulse_data();
        check("R6", 1'b0, "after status then data read");

        cur_req = "R9";
        highs(30);
        check("R9", 1'b0, "no re-set without new character");

        // R2: long frame
        cur_req = "R2";
        long_frame = 1'b1;
        send_char(9'h000, 9);
        highs(9);
        check("R2", 1'b0, "10 of 11 bit times");
        highs(1);
        check("R2", 1'b1, "11 of 11 bit times");
        clear_flag();
        long_frame = 1'b0;

        // R3: trailing high data bits count in mode 0
        cur_req = "R3";
        send_char(9'h0E0, 8);
        highs(5);
        check("R3", 1'b0, "3 data + stop + 5");
        highs(1);
        check("R3", 1'b1, "3 data + stop + 6");
        clear_flag();

        // R4: same character, counting only after stop
        cur_req = "R4";
        idle_after_stop = 1'b1;
        send_char(9'h0E0, 8);
        highs(9);
        check("R4", 1'b0, "9 bit times after stop");
        highs(1);
        check("R4", 1'b1, "10 bit times after stop");
        clear_flag();
        idle_after_stop = 1'b0;

        // R5: low sample restarts the count
        cur_req = "R5";
        send_char(9'h000, 8);
        highs(4);
        bit_time(1'b0, 1'b0);
        highs(9);
        check("R5", 1'b0, "9 highs after low sample");
        highs(1);
        check("R5", 1'b1, "10 highs after low sample");

        // R11: character while flag up re-arms
        cur_req = "R11";
        char_loaded = 1'b1; step(); char_loaded = 1'b0;
        pulse_status();
        pulse_data();
        check("R11", 1'b0, "cleared on data read");
        step();
        check("R11", 1'b1, "re-raised from saturated count");
        clear_flag();
        highs(20);
        check("R9", 1'b0, "no re-arm left after second clear");

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule